// File: doc/BRIEF.md
# Daisy-Chained DMA Bus-Master Sequencer

This block lets a peripheral controller take over a shared, multiplexed address/data bus for a single data transfer. Local logic presents a request together with an address, a direction and, for stores, a data word. The sequencer raises a bus request and waits for the grant, which arrives through a priority daisy chain. While the sequencer is requesting or holds the bus, it keeps the grant from reaching devices further down the chain. When it is idle, it passes the grant on.

Once granted, the sequencer acknowledges and becomes bus master. It waits for the previous master's strobes to clear, then runs one fully interlocked cycle. That cycle is either a fetch (read from memory) or a store (write to memory). It then releases the bus and reports completion with a one-cycle pulse, and for a fetch it presents the word that was read. A bus initialize input aborts whatever is in progress.

Top module: `dma_master_seq`

## Requirements
- R1: One cycle after `req` is seen while idle, `dmr` is high. It stays high until `dmgi` is seen, and `sack` is low meanwhile.
- R2: While the sequencer is idle, `dmgo` follows `dmgi` in the same cycle. While it is requesting or is bus master (`dmr` or `sack` high), `dmgo` is low.
- R3: One cycle after `dmgi` is seen during a request, `dmr` is low and `sack` is high, and never are both high together.
- R4: After the grant, `sync_o` stays low for as long as the bus input `sync_in` or `rply` is high. The address phase begins in the cycle after both are seen low.
- R5: The address phase lasts exactly one cycle. In it, `sync_o` and `dal_oe` are high and `dal_out` carries the captured address. `wtbt` is high only for a store (`req_write`=1). The next cycle raises `din` or `dout` with `wtbt` low, so the address no longer sits on the lines.
- R6: A fetch holds `din` high with `dal_oe` low until `rply` is seen. At that point `dal_in` is latched into `rdata` and `din` drops, while `sync_o` stays high until `rply` is seen low.
- R7: A store holds `dout` and `dal_oe` high with `dal_out` equal to the captured data until `rply` is seen. Then `dout` and `dal_oe` drop, while `sync_o` stays high until `rply` is seen low.
- R8: `bank_sel` is high during the address phase exactly when the top BANK_BITS bits of the address are all ones. With the defaults this means addresses 0xE000 to 0xFFFF. It is low at all other times.
- R9: In the cycle after `rply` is seen low at the end of a cycle, `sync_o` and `sack` are low and `done` is high for that one cycle. No further request or cycle follows without a new `req`.
- R10: One cycle after `init` is seen high, `dmr`, `sack`, `sync_o`, `din`, `dout`, `wtbt`, `dal_oe`, `bank_sel` and `done` are low. A pending request is dropped and the grant passes again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| init | input | 1 | Bus initialize, aborts everything (active high) |
| req | input | 1 | Local transfer request, sampled while idle |
| req_addr | input | BUS_W | Transfer address |
| req_write | input | 1 | 1 = store to memory, 0 = fetch from memory |
| req_wdata | input | BUS_W | Data word for a store |
| dmgi | input | 1 | Grant in from the higher-priority side of the chain |
| rply | input | 1 | Slave reply |
| sync_in | input | 1 | Bus SYNC as seen on the shared line |
| dal_in | input | BUS_W | Shared address/data lines as received |
| dmr | output | 1 | Bus request |
| dmgo | output | 1 | Grant out to the lower-priority side of the chain |
| sack | output | 1 | Selection acknowledge, held while bus master |
| sync_o | output | 1 | SYNC driven by this master |
| din | output | 1 | Input (fetch) data strobe |
| dout | output | 1 | Output (store) data strobe |
| wtbt | output | 1 | Write indication during the address phase |
| bank_sel | output | 1 | Top-bank select during the address phase |
| dal_oe | output | 1 | Drive enable for the shared lines |
| dal_out | output | BUS_W | Address or data driven onto the shared lines |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | BUS_W | Word latched by the last fetch |

## Verification
The bench builds the block with BUS_W=16 and BANK_BITS=3. With these values the bank boundary falls at 0xE000, and addresses on both sides of it (0xDFFE, 0xE000, 0xFFFE) are easy to reach. The slave model keeps `rply` high for an extra cycle, which exposes whether SYNC waits for the reply to drop. A busy bus, held first through `sync_in` and then through `rply`, exposes the wait before the address phase. Initialize is applied both during a request and during the address phase.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_ADDR,
    ST_RD,
    ST_RD_END,
    ST_WR,
    ST_WR_END,
    ST_REL
  } dma_state_t;
endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/dma_bank_decode.sv
module dma_bank_decode #(
  parameter int BUS_W     = 16,
  parameter int BANK_BITS = 3
) (
  input  logic [BUS_W-1:0] addr,
  output logic             bank_hit
);
  localparam int BANK_LSB = BUS_W - BANK_BITS;

  assign bank_hit = &addr[BUS_W-1:BANK_LSB];
endmodule

// File: rtl/dma_grant_chain.sv
module dma_grant_chain (
  input  logic dmgi,
  input  logic idle,
  input  logic init,
  output logic dmgo
);
  // A device that is requesting or mastering swallows the grant.
  assign dmgo = dmgi & idle & ~init;
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_seq_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             req,
  input  logic [BUS_W-1:0] req_addr,
  input  logic             req_write,
  input  logic [BUS_W-1:0] req_wdata,
  input  logic             dmgi,
  input  logic             rply,
  input  logic             sync_in,
  input  logic [BUS_W-1:0] dal_in,
  input  logic             bank_hit,
  output logic [BUS_W-1:0] addr_q,
  output logic             idle,
  output logic             dmr,
  output logic             sack,
  output logic             sync_o,
  output logic             din,
  output logic             dout,
  output logic             wtbt,
  output logic             bank_sel,
  output logic             dal_oe,
  output logic [BUS_W-1:0] dal_out,
  output logic             done,
  output logic [BUS_W-1:0] rdata
);
  dma_state_t       state_q, state_d;
  logic [BUS_W-1:0] wdata_q, rdata_q;
  logic             write_q;
  logic             cap_en, rd_en;

  assign cap_en = (state_q == ST_IDLE) && req && !init;
  assign rd_en  = (state_q == ST_RD) && rply && !init;

  // next-state process
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (req)               state_d = ST_REQ;
      ST_REQ:    if (dmgi)              state_d = ST_WAIT;
      ST_WAIT:   if (!sync_in && !rply) state_d = ST_ADDR;
      ST_ADDR:   state_d = write_q ? ST_WR : ST_RD;
      ST_RD:     if (rply)              state_d = ST_RD_END;
      ST_RD_END: if (!rply)             state_d = ST_REL;
      ST_WR:     if (rply)              state_d = ST_WR_END;
      ST_WR_END: if (!rply)             state_d = ST_REL;
      ST_REL:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
    if (init) state_d = ST_IDLE;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        write_q <= req_write;
      end
      if (rd_en) rdata_q <= dal_in;
    end
  end

  // output decode
  assign idle     = (state_q == ST_IDLE);
  assign dmr      = (state_q == ST_REQ);
  assign sack     = (state_q == ST_WAIT) || (state_q == ST_ADDR) ||
                    (state_q == ST_RD)   || (state_q == ST_RD_END) ||
                    (state_q == ST_WR)   || (state_q == ST_WR_END);
  assign sync_o   = (state_q == ST_ADDR) ||
                    (state_q == ST_RD)   || (state_q == ST_RD_END) ||
                    (state_q == ST_WR)   || (state_q == ST_WR_END);
  assign din      = (state_q == ST_RD);
  assign dout     = (state_q == ST_WR);
  assign wtbt     = (state_q == ST_ADDR) && write_q;
  assign bank_sel = (state_q == ST_ADDR) && bank_hit;
  assign dal_oe   = (state_q == ST_ADDR) || (state_q == ST_WR);
  assign dal_out  = (state_q == ST_ADDR) ? addr_q :
                    (state_q == ST_WR)   ? wdata_q : '0;
  assign done     = (state_q == ST_REL);
  assign rdata    = rdata_q;

  // R3
  dmr_sack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmr && sack));

  // R6 R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(din && dout));

  // R4
  sync_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |-> $past(!sync_in && !rply));

  // R5
  addr_then_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) && !init |=> (din || dout) && !wtbt);

  // R6
  din_under_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    din |-> sync_o && sack && !dal_oe);

  // R9
  sync_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_o) && !$past(init) |-> !$past(rply) && done && !sack);

  // R10
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(init) |-> !dmr && !sack && !sync_o && !din && !dout && !dal_oe);
endmodule

// File: rtl/dma_master_seq.sv
module dma_master_seq #(
  parameter int BUS_W     = 16,
  parameter int BANK_BITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             req,
  input  logic [BUS_W-1:0] req_addr,
  input  logic             req_write,
  input  logic [BUS_W-1:0] req_wdata,
  input  logic             dmgi,
  input  logic             rply,
  input  logic             sync_in,
  input  logic [BUS_W-1:0] dal_in,
  output logic             dmr,
  output logic             dmgo,
  output logic             sack,
  output logic             sync_o,
  output logic             din,
  output logic             dout,
  output logic             wtbt,
  output logic             bank_sel,
  output logic             dal_oe,
  output logic [BUS_W-1:0] dal_out,
  output logic             done,
  output logic [BUS_W-1:0] rdata
);
  logic             rst_i_n;
  logic             idle;
  logic             bank_hit;
  logic [BUS_W-1:0] addr_q;

  dma_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  dma_bank_decode #(.BUS_W(BUS_W), .BANK_BITS(BANK_BITS)) u_bank (
    .addr     (addr_q),
    .bank_hit (bank_hit)
  );

  dma_grant_chain u_chain (
    .dmgi (dmgi),
    .idle (idle),
    .init (init),
    .dmgo (dmgo)
  );

  dma_xfer_fsm #(.BUS_W(BUS_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .init      (init),
    .req       (req),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .dmgi      (dmgi),
    .rply      (rply),
    .sync_in   (sync_in),
    .dal_in    (dal_in),
    .bank_hit  (bank_hit),
    .addr_q    (addr_q),
    .idle      (idle),
    .dmr       (dmr),
    .sack      (sack),
    .sync_o    (sync_o),
    .din       (din),
    .dout      (dout),
    .wtbt      (wtbt),
    .bank_sel  (bank_sel),
    .dal_oe    (dal_oe),
    .dal_out   (dal_out),
    .done      (done),
    .rdata     (rdata)
  );

  // R2
  grant_block_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (dmr || sack) |-> !dmgo);
endmodule

// File: tb/sim_dma_master_seq.sv
module sim_dma_master_seq;
  localparam int BUS_W     = 16;
  localparam int BANK_BITS = 3;

  logic             clk = 1'b0;
  logic             rst_n, init, req, req_write, dmgi, rply, sync_in;
  logic [BUS_W-1:0] req_addr, req_wdata, dal_in;
  logic             dmr, dmgo, sack, sync_o, din, dout, wtbt, bank_sel, dal_oe, done;
  logic [BUS_W-1:0] dal_out, rdata;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dma_master_seq #(.BUS_W(BUS_W), .BANK_BITS(BANK_BITS)) u0 (
    .clk(clk), .rst_n(rst_n), .init(init), .req(req), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .dmgi(dmgi), .rply(rply),
    .sync_in(sync_in), .dal_in(dal_in), .dmr(dmr), .dmgo(dmgo), .sack(sack),
    .sync_o(sync_o), .din(din), .dout(dout), .wtbt(wtbt), .bank_sel(bank_sel),
    .dal_oe(dal_oe), .dal_out(dal_out), .done(done), .rdata(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0; init = 1'b0; req = 1'b0; req_write = 1'b0; dmgi = 1'b0;
    rply = 1'b0; sync_in = 1'b0; req_addr = '0; req_wdata = '0; dal_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset dmr", dmr, 0);
    chk("R3 reset sack", sack, 0);
    chk("R9 reset sync/done", {sync_o, done, din, dout}, 0);
  endtask

  task automatic test_pass();
    @(negedge clk);
    dmgi = 1'b1; #1;
    chk("R2 idle grant passes", dmgo, 1);
    dmgi = 1'b0; #1;
    chk("R2 grant follows low", dmgo, 0);
  endtask

  task automatic do_xfer(input bit wr, input logic [BUS_W-1:0] a,
                         input logic [BUS_W-1:0] d, input bit busy);
    logic exp_bank;
    exp_bank = (a >= 16'hE000);
    @(negedge clk);
    req = 1'b1; req_addr = a; req_write = wr; req_wdata = d; sync_in = busy; rply = 1'b0;
    @(negedge clk);
    req = 1'b0; req_addr = '0; req_wdata = '0;
    chk("R1 dmr after req", dmr, 1);
    chk("R1 no sack yet", sack, 0);
    dmgi = 1'b1; #1;
    chk("R2 grant blocked while requesting", dmgo, 0);
    @(negedge clk);
    chk("R3 dmr dropped", dmr, 0);
    chk("R3 sack raised", sack, 1);
    chk("R2 grant blocked while master", dmgo, 0);
    dmgi = 1'b0;
    if (busy) begin
      @(negedge clk);
      chk("R4 wait on sync_in", sync_o, 0);
      sync_in = 1'b0; rply = 1'b1;
      @(negedge clk);
      chk("R4 wait on rply", sync_o, 0);
      rply = 1'b0;
    end
    @(negedge clk);
    chk("R5 sync in address phase", sync_o, 1);
    chk("R5 address driven", {dal_oe, dal_out}, {1'b1, a});
    chk("R5 wtbt by direction", wtbt, wr);
    chk("R8 bank select", bank_sel, exp_bank);
    chk("R5 no strobe yet", {din, dout}, 0);
    @(negedge clk);
    chk("R5 wtbt/bank dropped", {wtbt, bank_sel}, 0);
    if (!wr) begin
      chk("R6 din raised", {din, dout}, 2'b10);
      chk("R5 address removed", dal_oe, 0);
      dal_in = d;
    end else begin
      chk("R7 dout raised", {din, dout}, 2'b01);
      chk("R7 data driven", {dal_oe, dal_out}, {1'b1, d});
    end
    rply = 1'b1;
    @(negedge clk);
    chk(wr ? "R7 strobe dropped" : "R6 strobe dropped", {din, dout, dal_oe}, 0);
    chk(wr ? "R7 sync held" : "R6 sync held", {sync_o, sack}, 2'b11);
    @(negedge clk);
    chk(wr ? "R7 sync held while rply" : "R6 sync held while rply", sync_o, 1);
    rply = 1'b0; dal_in = '0;
    @(negedge clk);
    chk("R9 released", {sync_o, sack}, 0);
    chk("R9 done pulse", done, 1);
    if (!wr) chk("R6 read data", rdata, d);
    @(negedge clk);
    chk("R9 single transfer", {done, dmr, sync_o, sack}, 0);
  endtask

  task automatic test_init();
    // abort in address phase
    @(negedge clk);
    req = 1'b1; req_addr = 16'h1234; req_write = 1'b0;
    @(negedge clk);
    req = 1'b0; dmgi = 1'b1;
    @(negedge clk);
    dmgi = 1'b0;
    @(negedge clk);
    chk("R10 precondition sync", sync_o, 1);
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    chk("R10 outputs cleared", {dmr, sack, sync_o, din, dout, wtbt, bank_sel, dal_oe, done}, 0);
    @(negedge clk);
    chk("R10 stays idle", {dmr, sack, sync_o}, 0);
    // abort while requesting
    req = 1'b1; req_addr = 16'hF000;
    @(negedge clk);
    req = 1'b0;
    chk("R10 request pending", dmr, 1);
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    chk("R10 request dropped", {dmr, sack}, 0);
    dmgi = 1'b1; #1;
    chk("R10 grant passes after abort", dmgo, 1);
    @(negedge clk);
    chk("R10 no master after abort", {sack, sync_o}, 0);
    dmgi = 1'b0;
  endtask

  initial begin
    test_reset();
    test_pass();
    do_xfer(1'b0, 16'h2468, 16'hBEEF, 1'b0);
    do_xfer(1'b1, 16'hE000, 16'h5A5A, 1'b1);
    do_xfer(1'b0, 16'hDFFE, 16'h0F0F, 1'b1);
    do_xfer(1'b1, 16'hFFFE, 16'hC3C3, 1'b0);
    test_init();
    test_pass();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule